// File: doc/BRIEF.md
# Configuration Scrub Controller

This block keeps the configuration of a reprogrammable logic device correct on its own. With no help from the host it reads back the device's configuration one word at a time and fetches the matching golden word from flash. It compares the two under a per-word ignore mask that is also stored in flash. When it finds an unmasked difference, it stops the scan and writes the whole golden image back into the device. It then waits for the device to report that configuration is done, with a timeout, and resumes scanning.

The host only watches and steers. It sees a sticky "corrected" flag, a sticky "timeout" flag, the current sequencer state and an 8-bit saturating count of corrections. It can ask for a full reload at any time. It can also pause scanning, and the pause takes effect at the end of the current frame of words. The flash, readback and configuration ports are plain word-level handshakes. The flash and readback word orders are fixed at address 0 up to the last word.

Top module: `scrub_ctrl`

## Requirements
- R1: While reset is applied, the count register reads 0, the status register reads 0, and no readback request and no configuration word are presented.
- R2: With pause clear, the controller scans without host action. It requests readback words and flash words at addresses 0, 1, … up to WORDS-1 in that order, then starts again at 0.
- R3: A word is in error only when (readback XOR golden) AND NOT mask is nonzero, where a mask bit of 1 marks a bit to ignore. Changes confined to masked bits never cause a reload.
- R4: An error starts a reload. A one-cycle start pulse is followed by exactly WORDS configuration words, taken from flash at addresses 0 upward. Each word is held stable with valid high until ready is seen.
- R5: After the last pushed word, a done pulse ends a reload started by an error. It adds one to the count, sets the corrected flag (status bit 0) and scanning resumes.
- R6: If done does not arrive within TIMEOUT cycles after the last word, the timeout flag (status bit 1) is set and the count is unchanged.
- R7: The count saturates at 255 and does not wrap.
- R8: Writing any value to address 2 clears the count. Writing 1 to status bit 0 or bit 1 clears that flag.
- R9: Setting control bit 0 (address 0) pauses scanning after the last word of the current frame of FRAME_WORDS words. While paused, no readback is requested and an error in the device stays uncorrected. Clearing the bit resumes scanning at address 0.
- R10: Writing 1 to control bit 1 requests a reload, which starts once the sequencer is idle. A reload requested this way neither counts nor sets the corrected flag.
- R11: The status register (address 1) reports the busy state in bit 2 and the sequencer state in bits 5:4 (0 idle, 1 scan, 2 reload, 3 waiting for done).
- R12: A flash or readback request stays high with a stable address until its acknowledge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access select |
| hst_wr | input | 1 | Host write (1) or read (0) |
| hst_addr | input | 2 | Host register address |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data, valid while selected |
| fl_req | output | 1 | Flash word request |
| fl_addr | output | log2(WORDS) | Flash word address |
| fl_ack | input | 1 | Flash acknowledge, data and mask valid |
| fl_data | input | DATA_W | Golden configuration word |
| fl_mask | input | DATA_W | Ignore mask for the word |
| rb_req | output | 1 | Readback word request |
| rb_addr | output | log2(WORDS) | Readback word address |
| rb_ack | input | 1 | Readback acknowledge, data valid |
| rb_data | input | DATA_W | Word read back from the device |
| cfg_start | output | 1 | One-cycle pulse opening a reload |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_data | output | DATA_W | Configuration word |
| cfg_ready | input | 1 | Device accepts the configuration word |
| cfg_done | input | 1 | Device reports configuration complete |

## Verification
The assertions check, on every cycle, the port handshakes: flash and readback requests held stable, and configuration words held until accepted. They also check counter saturation, the counter holding when nothing changes it, clearing on write, the bound on the timeout counter, the paused idle state, and the step from a detected error into reload. The bench scenarios are the only way to show end-to-end effects. These are that an injected upset leaves the device image equal to the golden image, that masked noise never causes a reload, that the pause lands on a frame boundary and resumes at word 0, that reloads requested by the host go uncounted, and that the timeout fires at the right distance from the last word.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_LOAD = 2'd2,
    ST_WAIT = 2'd3
  } scrub_state_e;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_CHECK = 2'd1,
    PH_PUSH  = 2'd2
  } scrub_phase_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;

endpackage

// File: rtl/scrub_cmp.sv
module scrub_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] seen_word,
  input  logic [DATA_W-1:0] gold_word,
  input  logic [DATA_W-1:0] ign_mask,
  output logic              word_bad
);

  logic [DATA_W-1:0] bit_bad;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign bit_bad[b] = (seen_word[b] ^ gold_word[b]) & ~ign_mask[b];
  end

  assign word_bad = |bit_bad;

endmodule

// File: rtl/scrub_regs.sv
module scrub_regs
  import scrub_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hst_sel,
  input  logic         hst_wr,
  input  logic [1:0]   hst_addr,
  input  logic [15:0]  hst_wdata,
  output logic [15:0]  hst_rdata,
  input  logic         fix_evt,
  input  logic         tmo_evt,
  input  logic         reload_take,
  input  scrub_state_e state_i,
  output logic         pause,
  output logic         reload_pend
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             fix_q, fix_d, tmo_q, tmo_d;
  logic             pause_q, pause_d, pend_q, pend_d;
  logic             wr_ctrl, wr_stat, wr_cnt, busy;
  logic             unused_wdata;

  assign unused_wdata = ^hst_wdata[15:2];

  assign wr_ctrl = hst_sel && hst_wr && (hst_addr == REG_CTRL);
  assign wr_stat = hst_sel && hst_wr && (hst_addr == REG_STAT);
  assign wr_cnt  = hst_sel && hst_wr && (hst_addr == REG_CNT);
  assign busy    = (state_i != ST_IDLE);

  always_comb begin
    cnt_en  = wr_cnt || (fix_evt && (cnt_q != CNT_MAX));
    cnt_d   = wr_cnt ? '0 : cnt_q + CNT_W'(1);
    fix_d   = (fix_q && !(wr_stat && hst_wdata[0])) || fix_evt;
    tmo_d   = (tmo_q && !(wr_stat && hst_wdata[1])) || tmo_evt;
    pause_d = wr_ctrl ? hst_wdata[0] : pause_q;
    if (wr_ctrl && hst_wdata[1]) begin
      pend_d = 1'b1;
    end else if (reload_take) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fix_q   <= 1'b0;
      tmo_q   <= 1'b0;
      pause_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      fix_q   <= fix_d;
      tmo_q   <= tmo_d;
      pause_q <= pause_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    hst_rdata = '0;
    if (hst_sel) begin
      unique case (hst_addr)
        REG_CTRL: hst_rdata = {15'd0, pause_q};
        REG_STAT: hst_rdata = {10'd0, state_i, 1'b0, busy, tmo_q, fix_q};
        REG_CNT:  hst_rdata = 16'(cnt_q);
        default:  hst_rdata = '0;
      endcase
    end
  end

  assign pause       = pause_q;
  assign reload_pend = pend_q;

  // R7: a full counter stays full unless cleared
  assert_cnt_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !wr_cnt) |=> (cnt_q == CNT_MAX));

  // R5: the counter moves only on a correction or a clear
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !fix_evt) |=> $stable(cnt_q));

  // R8: a write to the count address empties it
  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == '0));

endmodule

// File: rtl/scrub_fsm.sv
module scrub_fsm
  import scrub_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FRAME_WORDS = 8,
  parameter int FRAMES      = 4,
  parameter int TIMEOUT     = 1024,
  localparam int WORDS      = FRAMES * FRAME_WORDS,
  localparam int AW         = $clog2(WORDS),
  localparam int TW         = $clog2(TIMEOUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause,
  input  logic              reload_pend,
  output logic              reload_take,
  output logic              fix_evt,
  output logic              tmo_evt,
  output scrub_state_e      state,
  output logic              fl_req,
  output logic [AW-1:0]     fl_addr,
  input  logic              fl_ack,
  input  logic [DATA_W-1:0] fl_data,
  input  logic [DATA_W-1:0] fl_mask,
  output logic              rb_req,
  output logic [AW-1:0]     rb_addr,
  input  logic              rb_ack,
  input  logic [DATA_W-1:0] rb_data,
  output logic              cfg_start,
  output logic              cfg_valid,
  output logic [DATA_W-1:0] cfg_data,
  input  logic              cfg_ready,
  input  logic              cfg_done
);

  scrub_state_e      state_q, state_d;
  scrub_phase_e      phase_q, phase_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic              flg_q, flg_d, rbg_q, rbg_d;
  logic [DATA_W-1:0] gold_q, gold_d, mask_q, mask_d, seen_q, seen_d;
  logic [TW-1:0]     tmo_q, tmo_d;
  logic              auto_q, auto_d, start_q, start_d;
  logic              word_bad, last_word, frame_end;

  scrub_cmp #(.DATA_W(DATA_W)) u_cmp (
    .seen_word (seen_q),
    .gold_word (gold_q),
    .ign_mask  (mask_q),
    .word_bad  (word_bad)
  );

  assign last_word = (addr_q == AW'(WORDS - 1));
  assign frame_end = ((int'(addr_q) % FRAME_WORDS) == FRAME_WORDS - 1);

  assign fl_req    = ((state_q == ST_SCAN) || (state_q == ST_LOAD)) &&
                     (phase_q == PH_FETCH) && !flg_q;
  assign rb_req    = (state_q == ST_SCAN) && (phase_q == PH_FETCH) && !rbg_q;
  assign fl_addr   = addr_q;
  assign rb_addr   = addr_q;
  assign cfg_valid = (state_q == ST_LOAD) && (phase_q == PH_PUSH);
  assign cfg_data  = gold_q;
  assign cfg_start = start_q;
  assign state     = state_q;

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    addr_d      = addr_q;
    flg_d       = flg_q;
    rbg_d       = rbg_q;
    gold_d      = gold_q;
    mask_d      = mask_q;
    seen_d      = seen_q;
    tmo_d       = tmo_q;
    auto_d      = auto_q;
    start_d     = 1'b0;
    fix_evt     = 1'b0;
    tmo_evt     = 1'b0;
    reload_take = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        addr_d  = '0;
        phase_d = PH_FETCH;
        flg_d   = 1'b0;
        rbg_d   = 1'b0;
        if (reload_pend) begin
          state_d     = ST_LOAD;
          auto_d      = 1'b0;
          reload_take = 1'b1;
          start_d     = 1'b1;
        end else if (!pause) begin
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (phase_q == PH_FETCH) begin
          if (fl_req && fl_ack) begin
            flg_d  = 1'b1;
            gold_d = fl_data;
            mask_d = fl_mask;
          end
          if (rb_req && rb_ack) begin
            rbg_d  = 1'b1;
            seen_d = rb_data;
          end
          if (flg_q && rbg_q) begin
            phase_d = PH_CHECK;
          end
        end else begin
          flg_d   = 1'b0;
          rbg_d   = 1'b0;
          phase_d = PH_FETCH;
          if (word_bad) begin
            state_d = ST_LOAD;
            addr_d  = '0;
            auto_d  = 1'b1;
            start_d = 1'b1;
          end else if (last_word || (frame_end && pause)) begin
            state_d = ST_IDLE;
          end else begin
            addr_d = addr_q + AW'(1);
          end
        end
      end
      ST_LOAD: begin
        if (phase_q == PH_PUSH) begin
          if (cfg_ready) begin
            phase_d = PH_FETCH;
            if (last_word) begin
              state_d = ST_WAIT;
              tmo_d   = '0;
            end else begin
              addr_d = addr_q + AW'(1);
            end
          end
        end else if (fl_req && fl_ack) begin
          gold_d  = fl_data;
          phase_d = PH_PUSH;
        end
      end
      ST_WAIT: begin
        if (cfg_done) begin
          state_d = ST_IDLE;
          fix_evt = auto_q;
        end else if (tmo_q == TW'(TIMEOUT - 1)) begin
          state_d = ST_IDLE;
          tmo_evt = 1'b1;
        end else begin
          tmo_d = tmo_q + TW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_FETCH;
      addr_q  <= '0;
      flg_q   <= 1'b0;
      rbg_q   <= 1'b0;
      gold_q  <= '0;
      mask_q  <= '0;
      seen_q  <= '0;
      tmo_q   <= '0;
      auto_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      addr_q  <= addr_d;
      flg_q   <= flg_d;
      rbg_q   <= rbg_d;
      gold_q  <= gold_d;
      mask_q  <= mask_d;
      seen_q  <= seen_d;
      tmo_q   <= tmo_d;
      auto_q  <= auto_d;
      start_q <= start_d;
    end
  end

  // R12: flash request held with a steady address until acknowledged
  assert_fl_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr)));

  // R12: readback request held with a steady address until acknowledged
  assert_rb_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_req && !rb_ack) |=> (rb_req && $stable(rb_addr)));

  // R4: a configuration word stays on the port until accepted
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_ready) |=> (cfg_valid && $stable(cfg_data)));

  // R3: an unmasked difference leads straight into a reload
  assert_err_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN && phase_q == PH_CHECK && word_bad) |=>
    (state_q == ST_LOAD && cfg_start));

  // R6: the wait for done never runs past the limit
  assert_tmo_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (tmo_q < TW'(TIMEOUT)));

  // R9: idle with pause set and nothing requested stays idle
  assert_pause_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pause && !reload_pend) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int FRAME_WORDS = 8,
  parameter int FRAMES      = 4,
  parameter int TIMEOUT     = 1024,
  parameter int CNT_W       = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   hst_sel,
  input  logic                                   hst_wr,
  input  logic [1:0]                             hst_addr,
  input  logic [15:0]                            hst_wdata,
  output logic [15:0]                            hst_rdata,
  output logic                                   fl_req,
  output logic [$clog2(FRAMES*FRAME_WORDS)-1:0]  fl_addr,
  input  logic                                   fl_ack,
  input  logic [DATA_W-1:0]                      fl_data,
  input  logic [DATA_W-1:0]                      fl_mask,
  output logic                                   rb_req,
  output logic [$clog2(FRAMES*FRAME_WORDS)-1:0]  rb_addr,
  input  logic                                   rb_ack,
  input  logic [DATA_W-1:0]                      rb_data,
  output logic                                   cfg_start,
  output logic                                   cfg_valid,
  output logic [DATA_W-1:0]                      cfg_data,
  input  logic                                   cfg_ready,
  input  logic                                   cfg_done
);

  logic [1:0]   rst_pipe;
  logic         rst_n_int;
  logic         pause, reload_pend, reload_take, fix_evt, tmo_evt;
  scrub_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe[1];

  scrub_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .hst_sel     (hst_sel),
    .hst_wr      (hst_wr),
    .hst_addr    (hst_addr),
    .hst_wdata   (hst_wdata),
    .hst_rdata   (hst_rdata),
    .fix_evt     (fix_evt),
    .tmo_evt     (tmo_evt),
    .reload_take (reload_take),
    .state_i     (state),
    .pause       (pause),
    .reload_pend (reload_pend)
  );

  scrub_fsm #(
    .DATA_W      (DATA_W),
    .FRAME_WORDS (FRAME_WORDS),
    .FRAMES      (FRAMES),
    .TIMEOUT     (TIMEOUT)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .pause       (pause),
    .reload_pend (reload_pend),
    .reload_take (reload_take),
    .fix_evt     (fix_evt),
    .tmo_evt     (tmo_evt),
    .state       (state),
    .fl_req      (fl_req),
    .fl_addr     (fl_addr),
    .fl_ack      (fl_ack),
    .fl_data     (fl_data),
    .fl_mask     (fl_mask),
    .rb_req      (rb_req),
    .rb_addr     (rb_addr),
    .rb_ack      (rb_ack),
    .rb_data     (rb_data),
    .cfg_start   (cfg_start),
    .cfg_valid   (cfg_valid),
    .cfg_data    (cfg_data),
    .cfg_ready   (cfg_ready),
    .cfg_done    (cfg_done)
  );

endmodule

// File: tb/scrub_ctrl_bench.sv
module scrub_ctrl_bench;

  localparam int FW  = 4;
  localparam int FR  = 2;
  localparam int N   = FW * FR;
  localparam int AWB = 3;
  localparam int TMO = 40;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CNT  = 2'd2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           hst_sel, hst_wr;
  logic [1:0]     hst_addr;
  logic [15:0]    hst_wdata, hst_rdata;
  logic           fl_req, fl_ack, rb_req, rb_ack;
  logic [AWB-1:0] fl_addr, rb_addr;
  logic [15:0]    fl_data, fl_mask, rb_data, cfg_data;
  logic           cfg_start, cfg_valid, cfg_ready, cfg_done;

  logic [15:0] gold [N];
  logic [15:0] mask [N];
  logic [15:0] dev  [N];
  int rb_log [64];
  int rb_n = 0, rb_last = 0, hs_err = 0;
  int pushes = 0, widx = 0, loads_seen = 0, last_push_cyc = 0, cyc = 0;
  int n_chk = 0, n_fail = 0;
  bit stuck = 0, dyn = 1, done_en = 1;

  always #4 clk = ~clk;

  scrub_ctrl #(.DATA_W(16), .FRAME_WORDS(FW), .FRAMES(FR), .TIMEOUT(TMO), .CNT_W(8)) u_scrub_ctrl (
    .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .fl_req(fl_req), .fl_addr(fl_addr),
    .fl_ack(fl_ack), .fl_data(fl_data), .fl_mask(fl_mask), .rb_req(rb_req),
    .rb_addr(rb_addr), .rb_ack(rb_ack), .rb_data(rb_data), .cfg_start(cfg_start),
    .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_ready(cfg_ready), .cfg_done(cfg_done)
  );

  function automatic int exp_stat(int st, bit busy, bit tmo, bit fix);
    return (st << 4) | (int'(busy) << 2) | (int'(tmo) << 1) | int'(fix);
  endfunction

  function automatic int sat_add(int c, int n);
    return (c + n > 255) ? 255 : c + n;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_sel = 1'b0; hst_wr = 1'b0;
  endtask

  task automatic hr(logic [1:0] a, output int v);
    @(negedge clk);
    hst_sel = 1'b1; hst_wr = 1'b0; hst_addr = a;
    #1 v = int'(hst_rdata);
    hst_sel = 1'b0;
  endtask

  task automatic wait_cnt(int target, int maxc);
    int v;
    for (int k = 0; k < maxc; k += 10) begin
      hr(A_CNT, v);
      if (v == target) return;
      repeat (9) @(negedge clk);
    end
  endtask

  // flash responder with random latency
  initial begin
    logic [AWB-1:0] a;
    int d;
    fl_ack = 1'b0; fl_data = '0; fl_mask = '0;
    forever begin
      @(negedge clk);
      fl_ack = 1'b0;
      if (fl_req) begin
        a = fl_addr;
        d = int'($urandom % 3);
        repeat (d) begin
          @(negedge clk);
          if (!fl_req || fl_addr != a) hs_err++;
        end
        fl_ack = 1'b1; fl_data = gold[a]; fl_mask = mask[a];
      end
    end
  end

  // readback responder: device image plus noise on masked bits
  initial begin
    logic [AWB-1:0] a;
    int d;
    rb_ack = 1'b0; rb_data = '0;
    forever begin
      @(negedge clk);
      rb_ack = 1'b0;
      if (rb_req) begin
        a = rb_addr;
        d = int'($urandom % 3);
        repeat (d) begin
          @(negedge clk);
          if (!rb_req || rb_addr != a) hs_err++;
        end
        rb_ack  = 1'b1;
        rb_data = dev[a] ^ (dyn ? (16'($urandom) & mask[a]) : 16'h0) ^
                  ((stuck && a == 0) ? 16'h0001 : 16'h0);
        rb_log[rb_n % 64] = int'(a);
        rb_last = int'(a);
        rb_n++;
      end
    end
  end

  // configuration sink: record accepted words at the edge
  always @(posedge clk) begin
    cyc++;
    if (cfg_start) begin
      widx = 0;
    end else if (cfg_valid && cfg_ready) begin
      if (widx < N) dev[widx] = cfg_data;
      widx++;
      pushes++;
      if (widx == N) begin
        loads_seen++;
        last_push_cyc = cyc;
      end
    end
  end

  // ready and done driver
  initial begin
    int handled = 0, dly = 0;
    cfg_ready = 1'b0; cfg_done = 1'b0;
    forever begin
      @(negedge clk);
      cfg_ready = ($urandom % 4) != 0;
      cfg_done  = 1'b0;
      if (loads_seen != handled) begin
        handled = loads_seen;
        dly = 4;
      end
      if (dly > 0) begin
        dly--;
        if (dly == 0 && done_en) cfg_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, errs, base, mark, lastb, seed;
    seed = int'($urandom(32'd7719));
    rst_n = 1'b0; hst_sel = 1'b0; hst_wr = 1'b0; hst_addr = '0; hst_wdata = '0;
    for (int i = 0; i < N; i++) begin
      gold[i] = 16'($urandom);
      mask[i] = 16'($urandom & $urandom & $urandom) & 16'hFFFE;
      dev[i]  = gold[i];
    end
    repeat (4) @(negedge clk);
    // R1 reset state
    hr(A_CNT, v);  chk("R1 count", v, 0);
    hr(A_STAT, v); chk("R1 status", v, exp_stat(0, 0, 0, 0));
    chk("R1 cfg_valid", int'(cfg_valid), 0);
    chk("R1 rb_req", int'(rb_req), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2 autonomous ordered scan, R3 masked noise ignored
    for (int k = 0; k < 4000 && rb_n < 2 * N + 1; k++) @(negedge clk);
    errs = 0;
    for (int i = 0; i < 2 * N; i++) if (rb_log[i] != i % N) errs++;
    chk("R2 scan order", errs, 0);
    hr(A_CNT, v); chk("R3 masked noise", v, 0);

    // R4 R5 upset correction
    base = pushes;
    dev[5] = dev[5] ^ 16'h0001;
    wait_cnt(1, 3000);
    chk("R4 words pushed", pushes - base, N);
    errs = 0;
    for (int i = 0; i < N; i++) if (dev[i] != gold[i]) errs++;
    chk("R4 image restored", errs, 0);
    hr(A_CNT, v);  chk("R5 count", v, sat_add(0, 1));
    hr(A_STAT, v); chk("R5 flag", v & 3, 1);
    mark = rb_n;
    repeat (100) @(negedge clk);
    chk("R5 resume", int'(rb_n > mark), 1);

    // R8 clears
    hw(A_STAT, 16'h0001);
    hr(A_STAT, v); chk("R8 w1c", v & 3, 0);
    hw(A_CNT, 16'h00A5);
    hr(A_CNT, v); chk("R8 count clear", v, 0);

    // R9 pause at frame boundary
    hw(A_CTRL, 16'h0001);
    repeat (120) @(negedge clk);
    mark = rb_n; lastb = rb_last;
    hr(A_STAT, v); chk("R9 idle", v, exp_stat(0, 0, 0, 0));
    chk("R9 frame end", lastb % FW, FW - 1);
    dev[2] = dev[2] ^ 16'h0001;
    repeat (150) @(negedge clk);
    chk("R9 no readback", rb_n, mark);
    hr(A_CNT, v); chk("R9 no correction", v, 0);
    hw(A_CTRL, 16'h0000);
    wait_cnt(1, 3000);
    chk("R9 resume at 0", rb_log[mark % 64], 0);
    hr(A_CNT, v); chk("R9 corrected after resume", v, 1);

    // R10 host reload is uncounted
    hw(A_CTRL, 16'h0001);
    repeat (150) @(negedge clk);
    hw(A_STAT, 16'h0003);
    base = pushes;
    hw(A_CTRL, 16'h0003);
    repeat (250) @(negedge clk);
    chk("R10 words pushed", pushes - base, N);
    hr(A_CNT, v);  chk("R10 count", v, 1);
    hr(A_STAT, v); chk("R10 status", v, exp_stat(0, 0, 0, 0));

    // R6 R11 timeout
    done_en = 1'b0;
    base = pushes;
    hw(A_CTRL, 16'h0003);
    for (int k = 0; k < 2000 && pushes < base + N; k++) @(negedge clk);
    while (cyc < last_push_cyc + TMO - 5) @(negedge clk);
    hr(A_STAT, v); chk("R11 waiting state", v, exp_stat(3, 1, 0, 0));
    while (cyc < last_push_cyc + TMO + 5) @(negedge clk);
    hr(A_STAT, v); chk("R6 timeout flag", v, exp_stat(0, 0, 1, 0));
    hr(A_CNT, v);  chk("R6 count kept", v, 1);
    hw(A_STAT, 16'h0002);
    hr(A_STAT, v); chk("R8 timeout w1c", v & 3, 0);
    done_en = 1'b1;

    // R7 saturation under a stuck bit
    hw(A_CTRL, 16'h0000);
    hw(A_CNT, 16'h0000);
    stuck = 1'b1;
    wait_cnt(255, 60000);
    repeat (400) @(negedge clk);
    hr(A_CNT, v); chk("R7 saturated", v, sat_add(250, 10));
    stuck = 1'b0;

    chk("R12 handshake hold", hs_err, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule